// File: doc/BRIEF.md
# Configurable Registered Fan-Out Buffer

This block is a clocked register for an address and command bus. On each rising clock edge it captures a bank of inputs and drives them to its output ports. Two static shape inputs set how inputs map to outputs. In the wide shape, 25 inputs each drive one output. In the duplicate shape, 14 inputs each drive two output copies, using one of two mappings. In the first mapping, both copies sit on one 28-bit bus. In the second mapping, the copies are split across two ports.

Two active-low select inputs are sampled on the same edge as the data. When both are high, the register keeps its contents, so the outputs do not toggle. If either select is low, the register loads normally. With the rank select tied low, the device select has no gating effect.

An asynchronous active-low reset clears the register at once and overrides select gating. After reset is released, low data keeps the outputs low with no glitch.

Top module: `cfg_fanout_reg`

## Requirements
- R1: While `rst_n` is low, `q_main_o` and `q_alt_o` are all zeros. Reset clears them without waiting for a clock edge, whatever `d_i` holds.
- R2: With `wide_mode`=0 and a load enabled, `q_main_o[24:0]` equals `d_i[24:0]` as sampled at the previous rising edge.
- R3: With `wide_mode`=0, `q_main_o[27:25]` and all of `q_alt_o` are zero after the next edge.
- R4: With `wide_mode`=1 and `dup_variant`=0, bit i of `d_i` (i in 0..13) appears on `q_main_o[i]` and on `q_main_o[i+14]`. `q_alt_o` is zero, and `d_i[24:14]` has no effect on any output.
- R5: With `wide_mode`=1 and `dup_variant`=1, `d_i[13:0]` appears on both `q_main_o[13:0]` and `q_alt_o[13:0]`, and `q_main_o[27:14]` is zero.
- R6: When `cs_dev_n` and `cs_rank_n` are both high at a rising edge, both output ports keep their values across that edge.
- R7: When either `cs_dev_n` or `cs_rank_n` is low at a rising edge, the outputs load the mapped inputs. With `cs_rank_n` low, this holds even while `cs_dev_n` is high.
- R8: Reset forces all outputs to zero even while both selects request a hold.
- R9: After `rst_n` rises with `d_i` all zero, the outputs stay zero on every following edge for as long as `d_i` stays zero.
- R10: A change of `wide_mode` or `dup_variant` leaves the outputs unchanged until the next rising edge. From that edge on, the outputs follow the new shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_mode | input | 1 | 0: 25-bit one-to-one, 1: 14-bit duplicate |
| dup_variant | input | 1 | Duplicate mapping: 0 both copies on main bus, 1 second copy on alt port |
| cs_dev_n | input | 1 | Device select, active low |
| cs_rank_n | input | 1 | Rank select, active low |
| d_i | input | 25 | Address and command inputs |
| q_main_o | output | 28 | Main registered output bus |
| q_alt_o | output | 14 | Second-copy port used by duplicate mapping 1 |

## Verification
The mapping is tried with dense, alternating and all-ones data in each of the three shapes. These patterns separate a swapped or shifted copy, a missing duplicate, and leakage of the ignored upper inputs. Each of the four select combinations is applied with data that differs from the held value, so a hold shows up as a visible difference at the outputs. Reset is asserted in the middle of a cycle during a hold, and then released with zero data. These steps tell asynchronous clearing apart from clocked clearing, and show whether reset overrides the hold.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

    localparam int WIDE_W = 25;
    localparam int HALF_W = 14;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'd0,
        MODE_DUP_A = 2'd1,
        MODE_DUP_B = 2'd2
    } fan_mode_e;

    typedef struct packed {
        logic wide;
        logic vsel;
    } shape_t;

    function automatic fan_mode_e decode_mode(input shape_t s);
        if (!s.wide)
            return MODE_PASS;
        else if (!s.vsel)
            return MODE_DUP_A;
        else
            return MODE_DUP_B;
    endfunction

endpackage

// File: rtl/regbuf_gate.sv
module regbuf_gate (
    input  logic cs_dev_n,
    input  logic cs_rank_n,
    output logic load_en
);
    // both selects high freezes the register; any low select lets it load
    assign load_en = ~(cs_dev_n & cs_rank_n);
endmodule

// File: rtl/regbuf_map.sv
module regbuf_map
    import regbuf_pkg::*;
#(
    parameter int IN_W   = WIDE_W,
    parameter int HALF_W = regbuf_pkg::HALF_W
) (
    input  shape_t              shape,
    input  logic [IN_W-1:0]     d,
    output logic [2*HALF_W-1:0] main_nx,
    output logic [HALF_W-1:0]   alt_nx
);
    localparam int MAIN_W = 2 * HALF_W;

    logic [MAIN_W-1:0] pass_v, dupa_v, dupb_v;
    fan_mode_e         mode;

    assign mode = decode_mode(shape);

    for (genvar i = 0; i < MAIN_W; i++) begin : g_bit
        if (i < IN_W) begin : g_pass_in
            assign pass_v[i] = d[i];
        end else begin : g_pass_zero
            assign pass_v[i] = 1'b0;
        end
        if (i < HALF_W) begin : g_low
            assign dupa_v[i] = d[i];
            assign dupb_v[i] = d[i];
        end else begin : g_high
            assign dupa_v[i] = d[i-HALF_W];
            assign dupb_v[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_DUP_A: begin
                main_nx = dupa_v;
                alt_nx  = '0;
            end
            MODE_DUP_B: begin
                main_nx = dupb_v;
                alt_nx  = d[HALF_W-1:0];
            end
            default: begin
                main_nx = pass_v;
                alt_nx  = '0;
            end
        endcase
    end
endmodule

// File: rtl/regbuf_bank.sv
module regbuf_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_out <= '0;
        else if (load_en)
            q_out <= d_in;
    end

    // R1: reset holds the bank at zero
    p_clear_r1: assert property (@(posedge clk) !rst_n |-> q_out == '0)
        else $error("p_clear_r1");

    // R9: zero data into a zero bank never raises a bit
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_in == '0 && q_out == '0) |=> q_out == '0)
        else $error("p_quiet_r9");
endmodule

// File: rtl/cfg_fanout_reg.sv
module cfg_fanout_reg
    import regbuf_pkg::*;
#(
    parameter int IN_W   = WIDE_W,
    parameter int HALF_W = regbuf_pkg::HALF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wide_mode,
    input  logic                dup_variant,
    input  logic                cs_dev_n,
    input  logic                cs_rank_n,
    input  logic [IN_W-1:0]     d_i,
    output logic [2*HALF_W-1:0] q_main_o,
    output logic [HALF_W-1:0]   q_alt_o
);
    localparam int MAIN_W = 2 * HALF_W;

    shape_t            shape;
    logic              load_en;
    logic [MAIN_W-1:0] main_nx;
    logic [HALF_W-1:0] alt_nx;

    assign shape = '{wide: wide_mode, vsel: dup_variant};

    regbuf_gate u_gate (
        .cs_dev_n  (cs_dev_n),
        .cs_rank_n (cs_rank_n),
        .load_en   (load_en)
    );

    regbuf_map #(.IN_W(IN_W), .HALF_W(HALF_W)) u_map (
        .shape   (shape),
        .d       (d_i),
        .main_nx (main_nx),
        .alt_nx  (alt_nx)
    );

    regbuf_bank #(.W(MAIN_W)) u_main (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .d_in    (main_nx),
        .q_out   (q_main_o)
    );

    regbuf_bank #(.W(HALF_W)) u_alt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .d_in    (alt_nx),
        .q_out   (q_alt_o)
    );

    // R2 and R7: an enabled one-to-one edge copies the inputs
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode && !(cs_dev_n && cs_rank_n)) |=> q_main_o[IN_W-1:0] == $past(d_i))
        else $error("p_pass_r2");

    // R3: unused outputs stay low in the one-to-one shape
    p_pass_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode && !(cs_dev_n && cs_rank_n)) |=> (q_main_o[MAIN_W-1:IN_W] == '0 && q_alt_o == '0))
        else $error("p_pass_hi_r3");

    // R4: mapping A carries two identical halves on the main bus
    p_dup_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && !dup_variant && !(cs_dev_n && cs_rank_n))
        |=> (q_main_o[HALF_W-1:0] == q_main_o[MAIN_W-1:HALF_W] && q_alt_o == '0
             && q_main_o[HALF_W-1:0] == $past(d_i[HALF_W-1:0])))
        else $error("p_dup_a_r4");

    // R5: mapping B mirrors the low half onto the alt port
    p_dup_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && dup_variant && !(cs_dev_n && cs_rank_n))
        |=> (q_alt_o == q_main_o[HALF_W-1:0] && q_main_o[MAIN_W-1:HALF_W] == '0))
        else $error("p_dup_b_r5");

    // R6: both selects high freezes both ports
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_dev_n && cs_rank_n) |=> ($stable(q_main_o) && $stable(q_alt_o)))
        else $error("p_hold_r6");
endmodule

// File: tb/cfg_fanout_reg_test.sv
module cfg_fanout_reg_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    // vector fields: [28] wide, [27] variant, [26] dev_n, [25] rank_n, [24:0] data
    localparam logic [28:0] VEC [NV] = '{
        {4'b0000, 25'h1ABCDEF},
        {4'b0010, 25'h0F0F0F0},
        {4'b0001, 25'h1555555},
        {4'b0011, 25'h0AAAAAA},
        {4'b1000, 25'h1FF3A5C},
        {4'b1011, 25'h0000000},
        {4'b1001, 25'h0002AAA},
        {4'b1100, 25'h1FE1234},
        {4'b1111, 25'h1FFFFFF},
        {4'b1110, 25'h0003FFF},
        {4'b0000, 25'h1FFFFFF},
        {4'b0011, 25'h0000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0, dup_variant = 1'b0;
    logic        cs_dev_n = 1'b0, cs_rank_n = 1'b0;
    logic [24:0] d_i = '0;
    logic [27:0] q_main_o;
    logic [13:0] q_alt_o;

    int total = 0;
    int bad = 0;
    logic [27:0] exp_main = '0;
    logic [13:0] exp_alt = '0;

    cfg_fanout_reg uut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .dup_variant(dup_variant),
        .cs_dev_n(cs_dev_n), .cs_rank_n(cs_rank_n), .d_i(d_i),
        .q_main_o(q_main_o), .q_alt_o(q_alt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [27:0] want_main(input logic w, input logic v, input logic [24:0] d);
        logic [27:0] r;
        r = '0;
        if (!w) r[24:0] = d;
        else if (!v) r = {d[13:0], d[13:0]};
        else r[13:0] = d[13:0];
        return r;
    endfunction

    function automatic logic [13:0] want_alt(input logic w, input logic v, input logic [24:0] d);
        return (w && v) ? d[13:0] : 14'h0;
    endfunction

    task automatic check(input string req, input logic [27:0] em, input logic [13:0] ea);
        total++;
        if (q_main_o !== em || q_alt_o !== ea) begin
            bad++;
            $display("FAIL %s: main=%h alt=%h expected main=%h alt=%h", req, q_main_o, q_alt_o, em, ea);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not complete");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state, then nonzero data during reset
        repeat (2) @(negedge clk);
        check("R1", '0, '0);
        d_i = '1;
        repeat (2) @(negedge clk);
        check("R1", '0, '0);
        // R9: release with zero data
        d_i = '0;
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9", '0, '0);
        end

        // table walk: R2 R3 R4 R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            logic w, v, dn, rn;
            string tag;
            {w, v, dn, rn} = VEC[k][28:25];
            wide_mode = w; dup_variant = v; cs_dev_n = dn; cs_rank_n = rn;
            d_i = VEC[k][24:0];
            @(negedge clk);
            if (!(dn && rn)) begin
                exp_main = want_main(w, v, VEC[k][24:0]);
                exp_alt  = want_alt(w, v, VEC[k][24:0]);
            end
            if (dn && rn) tag = "R6";
            else if (dn || rn) tag = "R7";
            else if (!w) tag = "R2 R3";
            else if (!v) tag = "R4";
            else tag = "R5";
            check(tag, exp_main, exp_alt);
        end

        // R10: shape change waits for the next edge (outputs currently all-ones pass, held)
        cs_dev_n = 1'b0; cs_rank_n = 1'b0;
        d_i = 25'h1FFFFFF;
        @(negedge clk);
        check("R2", 28'h1FFFFFF, '0);
        wide_mode = 1'b1; dup_variant = 1'b0;
        #(CLK_PERIOD/4);
        check("R10", 28'h1FFFFFF, '0);
        @(negedge clk);
        check("R10", 28'hFFFFFFF, '0);

        // R8 and R1: asynchronous reset during a hold, mid low phase
        cs_dev_n = 1'b1; cs_rank_n = 1'b1;
        #2;
        rst_n = 1'b0;
        #1;
        check("R1", '0, '0);
        @(negedge clk);
        check("R8", '0, '0);

        // R9: release with zero data and active selects
        d_i = '0; cs_dev_n = 1'b0; cs_rank_n = 1'b0;
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9", '0, '0);
        end

        // R5 after reset recovery
        dup_variant = 1'b1;
        d_i = 25'h0001234;
        @(negedge clk);
        check("R5", 28'h0001234, 14'h1234);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule